// File: doc/BRIEF.md
# Start/Done Handshake Controller for a Fixed-Latency Multiply-Accumulate

This block puts a block-level request/completion handshake around a small multi-cycle compute engine. A requester raises `start_i` with an operand on `din_i`. The controller latches the operand and runs a serial multiply-accumulate for a fixed number of cycles, set by a parameter. It then presents the sum on `result_o` together with a one-cycle completion pulse on `done_o` and `ready_o`.

The engine does not overlap transactions. In the completion cycle the controller samples `start_i` once more. If the request is still high, a new transaction begins at once with the operand present in that cycle, and the block never reports idle. If the request is low, the controller returns to its rest state, and `idle_o` rises one cycle after the completion pulse.

The computed value is `x * (1 + 2 + ... + (LAT-1))`, taken modulo 2^RW, where `x` is the latched operand. The engine adds `x*k` for k = 1 to LAT-1, one term per busy cycle.

Top module: `hsk_mac_top`

## Requirements
- R1: Reset is synchronous and active high. While it is applied and in the cycle after it, `idle_o` is 1 (with `start_i` low), `done_o` and `ready_o` are 0, and `result_o` is 0. A reset in the middle of a transaction abandons that transaction.
- R2: While resting, the block holds `idle_o` high and keeps `done_o`/`ready_o` low for as long as `start_i` is low, whatever value `din_i` carries.
- R3: In a resting cycle where `start_i` is 1, `idle_o` is 0 in that same cycle, and that clock edge begins a transaction.
- R4: If a transaction begins at clock edge E, `done_o` is high during exactly the cycle that follows edge E+(LAT-1), where LAT ≥ 2. That is LAT cycles after the cycle in which `start_i` was sampled.
- R5: `ready_o` is high in exactly the same cycles as `done_o`, and each pulse lasts one cycle.
- R6: While `done_o` is 1, `result_o` equals `x*LAT*(LAT-1)/2` modulo 2^RW. While `done_o` is 0, `result_o` is 0.
- R7: The operand is sampled only at the edge that begins a transaction. Changes on `din_i` during the busy cycles do not affect the result.
- R8: If `start_i` is 1 in a completion cycle, the next transaction begins at that edge with the `din_i` of that cycle, and `idle_o` stays 0 throughout.
- R9: If `start_i` is 0 in a completion cycle, the block comes to rest, and `idle_o` is 1 in the following cycle if `start_i` is still low.
- R10: `done_o`/`ready_o` never rise unless a transaction was begun and ran its full count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Transaction request, held high until `ready_o` |
| din_i | input | DW | Operand, sampled when a transaction begins |
| idle_o | output | 1 | High while resting and no request is present |
| ready_o | output | 1 | High in the cycle in which a new request is accepted after completion |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | RW | Accumulated result, nonzero only while `done_o` is high |

## Verification
The bench exercises several cases that a faulty controller would get wrong. A single transaction ends with the request dropped at completion; an off-by-one counter would move the `done_o` pulse away from cycle LAT, and an idle flag driven from the completion state would rise together with done instead of one cycle later. Back-to-back transactions keep `start_i` high through completion. A controller that passed through the rest state between them would show an `idle_o` blip and lose a cycle. Changing `din_i` during busy cycles catches an operand that is not latched, and a reset in mid-transaction together with the all-ones operand catches stale accumulators and width truncation.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

  // Controller phases: resting, accumulating, completion cycle.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } hsk_state_e;

  // Width of a counter that must hold values 0 .. n-1 (at least 1 bit).
  function automatic int cnt_bits(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/hsk_seq_ctrl.sv
module hsk_seq_ctrl
  import hsk_pkg::*;
#(
  parameter int LAT = 5,
  localparam int CW = cnt_bits(LAT)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          start_i,
  output logic          idle_o,
  output logic          cmpl_o,
  output logic          load_o,
  output logic          step_en_o,
  output logic          finish_o,
  output logic [CW-1:0] step_o
);

  localparam logic [CW-1:0] LAST_STEP = CW'(LAT - 2);

  hsk_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          accept;

  // A request is accepted while resting or in the completion cycle.
  assign accept    = start_i && (state_q == ST_IDLE || state_q == ST_DONE);
  assign load_o    = accept;
  assign step_en_o = (state_q == ST_RUN);
  assign finish_o  = (state_q == ST_RUN) && (cnt_q == LAST_STEP);
  assign step_o    = cnt_q;
  assign cmpl_o    = (state_q == ST_DONE);
  assign idle_o    = (state_q == ST_IDLE) && !start_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_RUN;
          cnt_d   = '0;
        end
      end
      ST_RUN: begin
        if (cnt_q == LAST_STEP) begin
          state_d = ST_DONE;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      ST_DONE: begin
        if (start_i) begin
          state_d = ST_RUN;
          cnt_d   = '0;
        end else begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    cmpl_o |=> !cmpl_o);

  // R10
  done_after_run_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    cmpl_o |-> $past(state_q) == ST_RUN);

  // R8
  restart_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (cmpl_o && start_i) |=> (state_q == ST_RUN && cnt_q == '0 && !idle_o));

  // R9
  rest_after_done_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (cmpl_o && !start_i) |=> (state_q == ST_IDLE));

  // R3
  begin_from_rest_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == ST_IDLE && start_i) |=> (state_q == ST_RUN && !cmpl_o));

  // R4
  step_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q == ST_RUN) |-> (cnt_q <= LAST_STEP));

endmodule

// File: rtl/hsk_mac_path.sv
module hsk_mac_path #(
  parameter int DW = 8,
  parameter int RW = 32,
  parameter int CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic [DW-1:0] din_i,
  input  logic          load_i,
  input  logic          step_en_i,
  input  logic          finish_i,
  input  logic [CW-1:0] step_i,
  input  logic          cmpl_i,
  output logic [RW-1:0] result_o
);

  logic [DW-1:0] x_q;
  logic [RW-1:0] acc_q;
  logic [RW-1:0] res_q;
  logic [CW:0]   weight;
  logic [RW-1:0] prod;
  logic [RW-1:0] sum;

  // Term k (1-based) of the series x*1 + x*2 + ... + x*(LAT-1).
  assign weight = {1'b0, step_i} + {{CW{1'b0}}, 1'b1};
  assign prod   = RW'(x_q) * RW'(weight);
  assign sum    = acc_q + prod;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      x_q   <= '0;
      acc_q <= '0;
      res_q <= '0;
    end else begin
      if (load_i) begin
        x_q   <= din_i;
        acc_q <= '0;
      end else if (step_en_i) begin
        acc_q <= sum;
      end
      if (finish_i) begin
        res_q <= sum;
      end
    end
  end

  assign result_o = cmpl_i ? res_q : '0;

  // R7
  operand_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (step_en_i && !load_i) |=> $stable(x_q));

  // R6
  result_gate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !cmpl_i |-> (result_o == '0));

endmodule

// File: rtl/hsk_mac_top.sv
module hsk_mac_top
  import hsk_pkg::*;
#(
  parameter int DW  = 8,
  parameter int RW  = 32,
  parameter int LAT = 5
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          start_i,
  input  logic [DW-1:0] din_i,
  output logic          idle_o,
  output logic          ready_o,
  output logic          done_o,
  output logic [RW-1:0] result_o
);

  localparam int CW = cnt_bits(LAT);

  logic          load;
  logic          step_en;
  logic          finish;
  logic          cmpl;
  logic [CW-1:0] step;

  hsk_seq_ctrl #(.LAT(LAT)) u_ctrl (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .start_i   (start_i),
    .idle_o    (idle_o),
    .cmpl_o    (cmpl),
    .load_o    (load),
    .step_en_o (step_en),
    .finish_o  (finish),
    .step_o    (step)
  );

  hsk_mac_path #(.DW(DW), .RW(RW), .CW(CW)) u_path (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .din_i     (din_i),
    .load_i    (load),
    .step_en_i (step_en),
    .finish_i  (finish),
    .step_i    (step),
    .cmpl_i    (cmpl),
    .result_o  (result_o)
  );

  // In the non-overlapping form, acceptance of the next request coincides with completion.
  assign done_o  = cmpl;
  assign ready_o = cmpl;

  // R9
  idle_excl_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |-> !idle_o);

endmodule

// File: tb/tb_hsk_mac_top.sv
module tb_hsk_mac_top;

  localparam int DW  = 8;
  localparam int RW  = 32;
  localparam int LAT = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [DW-1:0] din = '0;
  logic          idle, ready, done;
  logic [RW-1:0] result;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // Behavioural reference: 0 resting, 1 busy, 2 completion.
  int            m_phase = 0;
  int            m_left  = 0;
  logic [RW-1:0] m_res   = '0;

  always #10 clk = ~clk;

  hsk_mac_top #(.DW(DW), .RW(RW), .LAT(LAT)) dut (
    .clk_i    (clk),
    .rst_i    (rst),
    .start_i  (start),
    .din_i    (din),
    .idle_o   (idle),
    .ready_o  (ready),
    .done_o   (done),
    .result_o (result)
  );

  function automatic logic [RW-1:0] expect_val(input int x);
    logic [RW-1:0] s = '0;
    for (int k = 1; k < LAT; k++) s = s + RW'(x * k);
    return s;
  endfunction

  task automatic check(input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // One clock: drive at falling edge, compare, advance the model.
  task automatic cyc(input bit r, input bit s, input logic [DW-1:0] d, input string tag);
    @(negedge clk);
    rst = r; start = s; din = d;
    #1;
    check(tag, "idle",   idle,   (m_phase == 0 && !s));
    check(tag, "done",   done,   (m_phase == 2));
    check(tag, "ready",  ready,  (m_phase == 2));
    check(tag, "result", result, (m_phase == 2) ? m_res : '0);
    if (r) begin
      m_phase = 0; m_left = 0; m_res = '0;
    end else if (m_phase == 1) begin
      m_left--;
      if (m_left == 0) m_phase = 2;
    end else if (s) begin
      m_phase = 1; m_left = LAT - 1; m_res = expect_val(int'(d));
    end else begin
      m_phase = 0;
    end
  endtask

  // Hold start high with changing data until the completion cycle is next.
  task automatic wait_done(input logic [DW-1:0] junk, input string tag);
    int n = 0;
    while (m_phase != 2) begin
      cyc(1'b0, 1'b1, junk ^ DW'(n * 37), tag);
      n++;
    end
    check("R4", "busy cycles", n, LAT - 1);
  endtask

  initial begin
    // R1 reset state
    cyc(1'b1, 1'b0, 8'h00, "R1");
    cyc(1'b1, 1'b0, 8'hFF, "R1");
    cyc(1'b0, 1'b0, 8'h00, "R1");
    // R2 resting with data wiggling; R10 no completion without start
    for (int i = 0; i < 6; i++) cyc(1'b0, 1'b0, DW'(i * 29 + 3), "R2");
    check("R10", "no done at rest", done, 0);
    // Single transaction, request dropped at completion
    cyc(1'b0, 1'b1, 8'd7, "R3");
    wait_done(8'hA5, "R7");
    cyc(1'b0, 1'b0, 8'd0, "R9");
    cyc(1'b0, 1'b0, 8'd0, "R9");
    check("R9", "idle after done", idle, 1);
    // Back-to-back transactions
    cyc(1'b0, 1'b1, 8'd3, "R3");
    wait_done(8'h11, "R4");
    cyc(1'b0, 1'b1, 8'd200, "R8");
    wait_done(8'h22, "R8");
    cyc(1'b0, 1'b1, 8'd1, "R8");
    wait_done(8'h33, "R5");
    cyc(1'b0, 1'b0, 8'd9, "R5");
    cyc(1'b0, 1'b0, 8'd9, "R9");
    // Largest operand
    cyc(1'b0, 1'b1, 8'hFF, "R6");
    wait_done(8'h00, "R6");
    cyc(1'b0, 1'b0, 8'h00, "R6");
    // Zero operand
    cyc(1'b0, 1'b1, 8'h00, "R6");
    wait_done(8'hFF, "R6");
    cyc(1'b0, 1'b0, 8'h00, "R6");
    // Reset in the middle of a transaction
    cyc(1'b0, 1'b1, 8'd50, "R1");
    cyc(1'b0, 1'b1, 8'd50, "R1");
    cyc(1'b1, 1'b1, 8'd50, "R1");
    cyc(1'b0, 1'b0, 8'd50, "R1");
    for (int i = 0; i < LAT + 2; i++) cyc(1'b0, 1'b0, 8'd0, "R10");
    // Start arriving one cycle after a completion
    cyc(1'b0, 1'b1, 8'd12, "R3");
    wait_done(8'h44, "R4");
    cyc(1'b0, 1'b0, 8'd0, "R9");
    cyc(1'b0, 1'b1, 8'd13, "R3");
    wait_done(8'h55, "R7");
    cyc(1'b0, 1'b0, 8'd0, "R9");
    cyc(1'b0, 1'b0, 8'd0, "R2");
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule